// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Qualifier

This block sits behind the address comparators of a debug unit. Each comparator slot reports a raw address hit. The qualifier then decides whether that hit is allowed to become a debug event, using the slot's own control word. The control word restricts the hit by security state, by the privilege level of the access and, optionally, by a link to a context-ID comparator. That comparator is chosen from a bank of sixteen linked-breakpoint control/value pairs.

All slots are qualified in parallel, and their results are ORed into one event. The event is registered, so it appears on the clock edge after the inputs are presented. A global monitor-debug enable (bit 15 of the debug status word) and a debug-exception mask gate the whole result. One input selects whether the slots are watchpoints or breakpoints. For watchpoints, a flag marking an unprivileged load or store makes the access count as level 0.

Top module: `dbg_match_qualifier`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `match_q` is 0.
- R2: `match_q` equals the OR over all slots of each slot's qualified hit, computed from the inputs present at the previous rising clock edge. A slot whose `slot_hit` bit is 0 contributes nothing.
- R3: The security field is control bits 15:14. The value 0 passes in both states. The values 1 and 3 block the hit when `secure`=1. The value 2 blocks the hit when `secure`=0.
- R4: The privilege check uses an effective level. At level 2 or 3 it requires control bit 13. At level 1 it requires control bit 1. At level 0 it requires control bit 2.
- R5: When `is_watch`=1 and `unpriv_acc`=1, the effective level is 0 whatever `cur_el` is. When `is_watch`=0, `unpriv_acc` has no effect.
- R6: When control bit 20 is set, the hit also requires the linked entry whose index is in control bits 19:16. That entry fails if its index is above `BRK_CNT` or below `BRK_CNT-CTX_CNT`.
- R7: A linked entry passes only when three conditions hold: its bit 0 is 1, its type field (bits 23:20) equals 3, and `ctx_id` equals bits 31:0 of its value word. Every other type value fails.
- R8: A context-ID link never passes when `cur_el` is above 1. This uses the real level, even for unprivileged watchpoint accesses.
- R9: `match_q` is 0 in the cycle after one where `dbg_status[15]`=0 or `dbg_masked`=1. No other bit of `dbg_status` has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_hit | input | NSLOT | Raw address hit per slot |
| is_watch | input | 1 | 1: slots are watchpoints, 0: breakpoints |
| slot_ctrl | input | 32*NSLOT | Control word per slot, slot i at bits 32i+31:32i |
| cur_el | input | 2 | Current exception level |
| secure | input | 1 | Current security state (1 = secure) |
| unpriv_acc | input | 1 | Access is an unprivileged load/store |
| dbg_status | input | 32 | Debug status/control word, bit 15 is monitor-debug enable |
| dbg_masked | input | 1 | Debug exceptions masked at this point |
| link_ctrl | input | 512 | Sixteen linked-entry control words, entry k at bits 32k+31:32k |
| link_value | input | 1024 | Sixteen 64-bit linked-entry value words |
| ctx_id | input | 32 | Current context ID |
| match_q | output | 1 | Registered qualified debug event |

## Verification
The bench sweeps every combination of level, security state, unprivileged flag, slot kind, security field, privilege bits and hyp bit. A design that swapped the two privilege bits or handled security code 3 like code 0 fails on specific cells of that grid. It also walks the link index across all sixteen entries and the type field across all sixteen codes. This catches an off-by-one at either end of the comparator window and any type other than 3 being accepted. Two further cases target mistakes in level handling: an unprivileged watchpoint access at level 2 with a context link, and the global enable removed while every other field passes. The first catches a design that feeds the effective level into the context check. The second catches one that gates on the wrong status bit.

// File: rtl/dbg_match_qualifier.sv
module dbg_match_qualifier #(
  parameter int NSLOT   = 4,
  parameter int BRK_CNT = 5,
  parameter int CTX_CNT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSLOT-1:0]   slot_hit,
  input  logic               is_watch,
  input  logic [32*NSLOT-1:0] slot_ctrl,
  input  logic [1:0]         cur_el,
  input  logic               secure,
  input  logic               unpriv_acc,
  input  logic [31:0]        dbg_status,
  input  logic               dbg_masked,
  input  logic [511:0]       link_ctrl,
  input  logic [1023:0]      link_value,
  input  logic [31:0]        ctx_id,
  output logic               match_q
);
  localparam int NLINK = 16;
  localparam int CW    = 32;
  localparam int VW    = 64;
  localparam int LO_LNK = BRK_CNT - CTX_CNT;

  logic [NLINK-1:0] link_pass;
  logic [NSLOT-1:0] qual;
  logic [1:0]       eff_el;
  logic             ctx_el_ok;
  logic             global_on;

  assign eff_el    = (is_watch && unpriv_acc) ? 2'd0 : cur_el;
  assign ctx_el_ok = (cur_el <= 2'd1);
  assign global_on = dbg_status[15] && !dbg_masked;

  for (genvar k = 0; k < NLINK; k++) begin : g_link
    localparam bit IN_RANGE = (k <= BRK_CNT) && (k >= LO_LNK);
    logic [CW-1:0] lc;
    assign lc = link_ctrl[k*CW +: CW];
    assign link_pass[k] = IN_RANGE && lc[0] && (lc[23:20] == 4'd3) &&
                          ctx_el_ok && (ctx_id == link_value[k*VW +: 32]);
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [CW-1:0] cw;
    logic          sec_ok, priv_ok, lnk_ok;
    assign cw = slot_ctrl[i*CW +: CW];

    always_comb begin
      case (cw[15:14])
        2'd0:    sec_ok = 1'b1;
        2'd2:    sec_ok = secure;
        default: sec_ok = !secure;
      endcase
      case (eff_el)
        2'd0:    priv_ok = cw[2];
        2'd1:    priv_ok = cw[1];
        default: priv_ok = cw[13];
      endcase
    end

    assign lnk_ok  = !cw[20] || link_pass[cw[19:16]];
    assign qual[i] = slot_hit[i] && sec_ok && priv_ok && lnk_ok;

    // R3
    secure_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_hit == NSLOT'(1) << i) && secure && cw[14] |=> !match_q);
    // R3
    nonsecure_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_hit == NSLOT'(1) << i) && !secure && cw[15:14] == 2'd2 |=> !match_q);
    // R4
    hyp_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_hit == NSLOT'(1) << i) && cur_el >= 2'd2 && !(is_watch && unpriv_acc)
      && !cw[13] |=> !match_q);
    // R8
    ctx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_hit == NSLOT'(1) << i) && cw[20] && cur_el > 2'd1 |=> !match_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= global_on && (|qual);
  end

  // R9
  global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_status[15] || dbg_masked) |=> !match_q);
  // R2
  no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_hit == '0) |=> !match_q);
endmodule

// File: tb/sim_dbg_match_qualifier.sv
module sim_dbg_match_qualifier;
  localparam int NS = 2;
  localparam int BRK = 5;
  localparam int CTX = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic [NS-1:0] slot_hit = '0;
  logic is_watch = 0;
  logic [32*NS-1:0] slot_ctrl = '0;
  logic [1:0] cur_el = 0;
  logic secure = 0, unpriv_acc = 0, dbg_masked = 0;
  logic [31:0] dbg_status = 32'h0000_8000;
  logic [511:0] link_ctrl = '0;
  logic [1023:0] link_value = '0;
  logic [31:0] ctx_id = 32'h1234_5678;
  logic match_q;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_match_qualifier #(.NSLOT(NS), .BRK_CNT(BRK), .CTX_CNT(CTX)) u0 (
    .clk(clk), .rst_n(rst_n), .slot_hit(slot_hit), .is_watch(is_watch),
    .slot_ctrl(slot_ctrl), .cur_el(cur_el), .secure(secure),
    .unpriv_acc(unpriv_acc), .dbg_status(dbg_status), .dbg_masked(dbg_masked),
    .link_ctrl(link_ctrl), .link_value(link_value), .ctx_id(ctx_id),
    .match_q(match_q));

  function automatic bit link_model(int idx);
    int lc, typ;
    lc = link_ctrl[idx*32 +: 32];
    typ = (lc >> 20) & 15;
    if (idx > BRK || idx < BRK - CTX) return 0;
    if ((lc & 1) == 0) return 0;
    if (typ != 3) return 0;
    if (cur_el > 1) return 0;
    return ctx_id == link_value[idx*64 +: 32];
  endfunction

  function automatic bit slot_model(int s);
    int c, ssc, el;
    bit ok;
    c = slot_ctrl[s*32 +: 32];
    if (!slot_hit[s]) return 0;
    ssc = (c >> 14) & 3;
    if (ssc == 2 && !secure) return 0;
    if ((ssc == 1 || ssc == 3) && secure) return 0;
    el = (is_watch && unpriv_acc) ? 0 : cur_el;
    if (el >= 2) ok = (c >> 13) & 1;
    else if (el == 1) ok = (c >> 1) & 1;
    else ok = (c >> 2) & 1;
    if (!ok) return 0;
    if ((c >> 20) & 1) return link_model((c >> 16) & 15);
    return 1;
  endfunction

  function automatic bit top_model();
    bit any = 0;
    if (!dbg_status[15] || dbg_masked) return 0;
    for (int s = 0; s < NS; s++) any |= slot_model(s);
    return any;
  endfunction

  task automatic chk(bit exp, string tag);
    checks++;
    if (match_q !== exp) begin
      failures++;
      $display("FAIL %s: match_q=%0b expected=%0b (el=%0d sec=%0b up=%0b w=%0b ctrl=%h)",
               tag, match_q, exp, cur_el, secure, unpriv_acc, is_watch, slot_ctrl);
    end
  endtask

  task automatic step(string tag);
    bit e;
    e = top_model();
    @(posedge clk); #2;
    chk(e, tag);
  endtask

  function automatic logic [31:0] mk(int ssc, int pac, int hmc, int lnk, int lbn);
    return 32'((ssc << 14) | (pac << 1) | (hmc << 13) | (lnk << 20) | (lbn << 16));
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) begin
      link_ctrl[k*32 +: 32] = 32'h0030_0001;
      link_value[k*64 +: 64] = {32'hdead_beef, 32'h1234_5678};
    end
    repeat (3) @(posedge clk);
    #2; chk(1'b0, "R1 in reset");
    rst_n = 1;
    slot_hit = 2'b01; slot_ctrl = {32'h0, mk(0, 3, 1, 0, 0)};
    @(posedge clk); #2; chk(1'b1, "R1 first edge");

    // R3 R4 R5 full grid on slot 0
    for (int el = 0; el < 4; el++)
      for (int sc = 0; sc < 2; sc++)
        for (int up = 0; up < 2; up++)
          for (int w = 0; w < 2; w++)
            for (int ssc = 0; ssc < 4; ssc++)
              for (int pac = 0; pac < 4; pac++)
                for (int h = 0; h < 2; h++) begin
                  cur_el = 2'(el); secure = sc[0]; unpriv_acc = up[0]; is_watch = w[0];
                  slot_ctrl = {32'h0, mk(ssc, pac, h, 0, 0)};
                  step("R3 R4 R5 grid");
                end

    // R6 R8 link index and level sweep
    secure = 0;
    for (int lbn = 0; lbn < 16; lbn++)
      for (int el = 0; el < 4; el++)
        for (int up = 0; up < 2; up++) begin
          cur_el = 2'(el); unpriv_acc = up[0]; is_watch = 1;
          slot_ctrl = {32'h0, mk(0, 3, 1, 1, lbn)};
          step("R6 R8 link range/level");
        end

    // R7 type, enable and context compare
    cur_el = 1; unpriv_acc = 0; is_watch = 0;
    slot_ctrl = {32'h0, mk(0, 3, 1, 1, 4)};
    for (int t = 0; t < 16; t++)
      for (int en = 0; en < 2; en++)
        for (int m = 0; m < 2; m++) begin
          link_ctrl[4*32 +: 32] = 32'((t << 20) | en);
          link_value[4*64 +: 32] = m ? 32'h1234_5678 : 32'h1234_5679;
          step("R7 linked entry");
        end
    link_ctrl[4*32 +: 32] = 32'h0030_0001;
    link_value[4*64 +: 32] = 32'h1234_5678;

    // R9 global gate
    slot_ctrl = {32'h0, mk(0, 3, 1, 0, 0)};
    dbg_status = 32'hffff_7fff; step("R9 enable bit low");
    dbg_status = 32'h0000_8000; dbg_masked = 1; step("R9 masked");
    dbg_masked = 0; step("R9 enabled");

    // R2 OR across slots and latency
    for (int hp = 0; hp < 4; hp++)
      for (int pa = 0; pa < 2; pa++)
        for (int pb = 0; pb < 2; pb++) begin
          slot_hit = 2'(hp);
          slot_ctrl = {mk(0, pb ? 3 : 0, 1, 0, 0), mk(0, pa ? 3 : 0, 1, 0, 0)};
          step("R2 slot OR");
        end
    slot_hit = 2'b10; slot_ctrl = {mk(0, 3, 1, 0, 0), 32'h0};
    step("R2 slot1 only");
    slot_hit = 2'b00;
    #2; chk(1'b1, "R2 one-cycle latency");
    step("R2 no hit");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule